// File: doc/BRIEF.md
# Integer ALU with immediate extension

This block is the integer execution stage of a load-store RISC core. Each issued operation brings two register operands, a 16-bit immediate, a 5-bit shift count and an operation code. The block picks the second operand from the register value or from the immediate. The immediate is sign-extended or zero-extended according to the operation. The block then computes the word result and a flag that requests an overflow trap.

The result and the trap flag are registered. An operation presented with `in_valid` high at a rising clock edge appears on `result`, `ovf_trap` and `out_valid` after that edge. While `in_valid` is low the result register keeps its value. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted operation, `result` is 0, `ovf_trap` is 0 and `out_valid` is 0.
- R2: An operation sampled with `in_valid` high is visible one clock edge later with `out_valid` high. When `in_valid` is low, `out_valid` goes low and `result` and `ovf_trap` keep their values whatever the other inputs do.
- R3: The codes ADD=0 and ADDU=1 return opa+opb. SUB=2 and SUBU=3 return opa-opb. All four wrap modulo 2^32 and give identical results for the signed and unsigned forms.
- R4: `ovf_trap` is 1 only for ADD, SUB and ADDI=4, and only when signed overflow occurs. Signed overflow means the two addends have the same sign and the sign of the sum differs from it, with opb inverted for subtraction. ADDU, SUBU, ADDIU and every other code give 0.
- R5: ADDI=4 and ADDIU=5 return opa plus the immediate sign-extended from bit 15. SLTI=18 and SLTIU=19 compare against the same sign-extended immediate.
- R6: ANDI=10, ORI=11 and XORI=12 combine opa with the immediate zero-extended to 32 bits.
- R7: AND=6, OR=7, XOR=8 and NOR=9 are bitwise on opa and opb. NOR returns the complement of the OR.
- R8: SLL=13 and SRL=14 shift opa by `shamt` and fill the vacated bits with zeros. SRA=15 fills them with copies of opa bit 31.
- R9: SLT=16 and SLTI return 1 when opa is below the second operand as signed numbers, otherwise 0. SLTU=17 and SLTIU use an unsigned comparison. SLTIU compares against the sign-extended immediate.
- R10: LUI=20 returns the immediate in bits 31:16 and zeros in bits 15:0.
- R11: Codes 21 to 31 return 0 and never raise `ovf_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe; also the clock enable of the result register |
| op_sel | input | 5 | Operation code |
| opa | input | 32 | First register operand, also the shift source |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift count |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 32 | Registered result |
| ovf_trap | output | 1 | Registered signed-overflow trap request |

## Verification
The hardest cases to reach from the ports are those where signed and unsigned readings of the same bits disagree. One is the trap at the exact two's-complement boundary, where 0x7FFFFFFF+1 must trap under ADD and ADDI but not under ADDU or ADDIU. Another is the unsigned compare against an immediate of 0xFFFF, which sign-extends to the largest unsigned word. The stimulus drives the same operand pairs under each code, so the only difference between runs is the extension or trap rule. A hold scenario changes every data input while `in_valid` is low and then checks that nothing moves.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,
    OP_ADDIU = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOR   = 5'd9,
    OP_ANDI  = 5'd10,
    OP_ORI   = 5'd11,
    OP_XORI  = 5'd12,
    OP_SLL   = 5'd13,
    OP_SRL   = 5'd14,
    OP_SRA   = 5'd15,
    OP_SLT   = 5'd16,
    OP_SLTU  = 5'd17,
    OP_SLTI  = 5'd18,
    OP_SLTIU = 5'd19,
    OP_LUI   = 5'd20
  } op_e;

  // immediate replaces opb and is sign-extended (R5)
  function automatic logic uses_simm(input logic [4:0] op);
    return (op == OP_ADDI) || (op == OP_ADDIU) ||
           (op == OP_SLTI) || (op == OP_SLTIU);
  endfunction

  // immediate replaces opb and is zero-extended (R6)
  function automatic logic uses_zimm(input logic [4:0] op);
    return (op == OP_ANDI) || (op == OP_ORI) || (op == OP_XORI);
  endfunction

  // operations allowed to raise the overflow trap (R4)
  function automatic logic may_trap(input logic [4:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
  endfunction

endpackage

// File: rtl/exu_rst_sync.sv
module exu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/exu_opnd_sel.sv
module exu_opnd_sel
  import exu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [4:0]       op,
  input  logic [XLEN-1:0]  opb,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  opnd_b
);
  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] simm_ext;
  logic [XLEN-1:0] zimm_ext;

  assign simm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign zimm_ext = {{PAD_W{1'b0}}, imm};

  always_comb begin
    if (uses_simm(op))      opnd_b = simm_ext;
    else if (uses_zimm(op)) opnd_b = zimm_ext;
    else                    opnd_b = opb;
  end
endmodule

// File: rtl/exu_arith.sv
module exu_arith
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum,
  output logic            ovf,
  output logic            lt_s,
  output logic            lt_u
);
  localparam int MSB = XLEN - 1;

  logic            do_sub;
  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   cmp_diff;

  assign do_sub = (op == OP_SUB) || (op == OP_SUBU);
  assign b_eff  = do_sub ? ~b : b;

  // adder shared by the add and subtract codes
  always_comb begin
    sum = a + b_eff + {{(XLEN-1){1'b0}}, do_sub};
    ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

  // separate subtractor for the compare codes; carry out 0 means a < b unsigned
  always_comb begin
    cmp_diff = {1'b0, a} + {1'b0, ~b} + {{XLEN{1'b0}}, 1'b1};
    lt_u     = ~cmp_diff[XLEN];
    lt_s     = (a[MSB] != b[MSB]) ? a[MSB] : cmp_diff[MSB];
  end
endmodule

// File: rtl/exu_logic_shift.sv
module exu_logic_shift
  import exu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [4:0]             op,
  input  logic [XLEN-1:0]        a,
  input  logic [XLEN-1:0]        b,
  input  logic [IMM_W-1:0]       imm,
  input  logic [$clog2(XLEN)-1:0] shamt,
  output logic [XLEN-1:0]        out
);
  localparam int SHW = $clog2(XLEN);

  logic            left;
  logic            fill;
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] stage [SHW+1];
  logic [XLEN-1:0] shr_out;
  logic [XLEN-1:0] shl_out;

  assign left = (op == OP_SLL);
  assign fill = (op == OP_SRA) ? a[XLEN-1] : 1'b0;

  // left shifts reuse the right shifter on a bit-reversed word
  genvar gi;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_rev
      assign src[gi]     = left ? a[XLEN-1-gi] : a[gi];
      assign shl_out[gi] = shr_out[XLEN-1-gi];
    end
  endgenerate

  assign stage[0] = src;

  generate
    for (gi = 0; gi < SHW; gi++) begin : g_stage
      localparam int DIST = 1 << gi;
      assign stage[gi+1] = shamt[gi]
        ? {{DIST{fill}}, stage[gi][XLEN-1:DIST]}
        : stage[gi];
    end
  endgenerate

  assign shr_out = stage[SHW];

  always_comb begin
    unique case (op)
      OP_AND, OP_ANDI: out = a & b;
      OP_OR,  OP_ORI:  out = a | b;
      OP_XOR, OP_XORI: out = a ^ b;
      OP_NOR:          out = ~(a | b);
      OP_SLL:          out = shl_out;
      OP_SRL, OP_SRA:  out = shr_out;
      OP_LUI:          out = {imm, {(XLEN-IMM_W){1'b0}}};
      default:         out = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       op_sel,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [IMM_W-1:0] imm,
  input  logic [SHW-1:0]   shamt,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             ovf_trap
);
  logic            rst_core_n;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] sum;
  logic            ovf_raw;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] ls_out;

  logic [XLEN-1:0] res_d, res_q;
  logic            trap_d, trap_q;
  logic            vld_q;

  exu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  exu_opnd_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .op     (op_sel),
    .opb    (opb),
    .imm    (imm),
    .opnd_b (opnd_b)
  );

  exu_arith #(.XLEN(XLEN)) u_arith (
    .op   (op_sel),
    .a    (opa),
    .b    (opnd_b),
    .sum  (sum),
    .ovf  (ovf_raw),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  exu_logic_shift #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ls (
    .op    (op_sel),
    .a     (opa),
    .b     (opnd_b),
    .imm   (imm),
    .shamt (shamt),
    .out   (ls_out)
  );

  // next-state: result select and trap gating
  always_comb begin
    trap_d = may_trap(op_sel) && ovf_raw;
    unique case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
      OP_ADDI, OP_ADDIU:  res_d = sum;
      OP_SLT, OP_SLTI:    res_d = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:  res_d = {{(XLEN-1){1'b0}}, lt_u};
      default:            res_d = ls_out;
    endcase
  end

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q  <= '0;
      trap_q <= 1'b0;
    end else if (in_valid) begin
      res_q  <= res_d;
      trap_q <= trap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) vld_q <= 1'b0;
    else             vld_q <= in_valid;
  end

  assign result    = res_q;
  assign ovf_trap  = trap_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/exu_checker.sv
module exu_checker
  import exu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [4:0]       op_sel,
  input logic [XLEN-1:0]  opa,
  input logic [XLEN-1:0]  opb,
  input logic [IMM_W-1:0] imm,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             ovf_trap
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ovf_trap)));

  p_addu_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_ADDU) |=> (result == $past(opa) + $past(opb)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_ADDI))
      |=> !ovf_trap);

  p_slt_bool_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == OP_SLT || op_sel == OP_SLTU ||
                  op_sel == OP_SLTI || op_sel == OP_SLTIU))
      |=> (result[XLEN-1:1] == '0));

  p_lui_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_LUI)
      |=> (result == {$past(imm), {(XLEN-IMM_W){1'b0}}}));

  p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > OP_LUI) |=> (result == '0 && !ovf_trap));
endmodule

bind int_exec_unit exu_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .opa       (opa),
  .opb       (opb),
  .imm       (imm),
  .out_valid (out_valid),
  .result    (result),
  .ovf_trap  (ovf_trap)
);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op_sel;
  logic [31:0] opa, opb;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_trap;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .imm(imm), .shamt(shamt),
    .out_valid(out_valid), .result(result), .ovf_trap(ovf_trap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  // issue one operation, then check result, trap and valid one edge later
  task automatic run_op(input string tag, input logic [4:0] op,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh,
                        input logic [31:0] exp_res, input logic exp_trap);
    @(negedge clk);
    op_sel = op; opa = a; opb = b; imm = im; shamt = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " trap"}, {31'b0, ovf_trap}, {31'b0, exp_trap});
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; opa = '0; opb = '0; imm = '0; shamt = '0;
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 32'd0);
    chk("R1 trap in reset", {31'b0, ovf_trap}, 32'd0);
    chk("R1 valid in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 result after release", result, 32'd0);
    chk("R1 valid after release", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_add_sub;
    run_op("R3 add", 5'd0, 32'd5, 32'hFFFF_FFFD, 16'h0, 5'd0, 32'd2, 1'b0);
    run_op("R3 subu", 5'd3, 32'd4, 32'd1, 16'h0, 5'd0, 32'd3, 1'b0);
    run_op("R4 add overflow", 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 32'h8000_0000, 1'b1);
    run_op("R4 addu no trap", 5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 32'h8000_0000, 1'b0);
    run_op("R4 sub overflow", 5'd2, 32'h8000_0000, 32'd1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b1);
    run_op("R4 subu no trap", 5'd3, 32'h8000_0000, 32'd1, 16'h0, 5'd0, 32'h7FFF_FFFF, 1'b0);
    run_op("R4 sub neg-neg ok", 5'd2, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0, 32'h8000_0001, 1'b0);
  endtask

  task automatic t_imm_arith;
    run_op("R5 addi neg imm", 5'd4, 32'd4, 32'hDEAD_BEEF, 16'hFFFF, 5'd0, 32'd3, 1'b0);
    run_op("R5 addi overflow R4", 5'd4, 32'h7FFF_FFFF, 32'd0, 16'h0001, 5'd0, 32'h8000_0000, 1'b1);
    run_op("R5 addiu no trap", 5'd5, 32'h7FFF_FFFF, 32'd0, 16'h0001, 5'd0, 32'h8000_0000, 1'b0);
    run_op("R5 addiu neg imm", 5'd5, 32'd0, 32'd0, 16'h8000, 5'd0, 32'hFFFF_8000, 1'b0);
  endtask

  task automatic t_logic;
    run_op("R6 andi", 5'd10, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 5'd0, 32'h0000_FFFF, 1'b0);
    run_op("R6 ori", 5'd11, 32'h1234_0000, 32'd0, 16'h8001, 5'd0, 32'h1234_8001, 1'b0);
    run_op("R6 xori", 5'd12, 32'hFFFF_0000, 32'hFFFF_FFFF, 16'hFFFF, 5'd0, 32'hFFFF_FFFF, 1'b0);
    run_op("R7 and", 5'd6, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 5'd0, 32'hF000_F000, 1'b0);
    run_op("R7 or", 5'd7, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 5'd0, 32'hFFF0_FFF0, 1'b0);
    run_op("R7 xor", 5'd8, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 5'd0, 32'h0FF0_0FF0, 1'b0);
    run_op("R7 nor", 5'd9, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 5'd0, 32'h000F_000F, 1'b0);
  endtask

  task automatic t_shift;
    run_op("R8 sll", 5'd13, 32'd1, 32'd0, 16'h0, 5'd5, 32'h0000_0020, 1'b0);
    run_op("R8 sll edge", 5'd13, 32'hFFFF_FFFF, 32'd0, 16'h0, 5'd31, 32'h8000_0000, 1'b0);
    run_op("R8 srl", 5'd14, 32'h8000_0000, 32'd0, 16'h0, 5'd4, 32'h0800_0000, 1'b0);
    run_op("R8 sra neg", 5'd15, 32'h8000_0000, 32'd0, 16'h0, 5'd4, 32'hF800_0000, 1'b0);
    run_op("R8 sra pos", 5'd15, 32'h4000_0000, 32'd0, 16'h0, 5'd4, 32'h0400_0000, 1'b0);
    run_op("R8 sra 31", 5'd15, 32'h8000_0000, 32'd0, 16'h0, 5'd31, 32'hFFFF_FFFF, 1'b0);
    run_op("R8 shift 0", 5'd14, 32'hA5A5_A5A5, 32'd0, 16'h0, 5'd0, 32'hA5A5_A5A5, 1'b0);
  endtask

  task automatic t_compare;
    run_op("R9 slt signed", 5'd16, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 32'd1, 1'b0);
    run_op("R9 sltu unsigned", 5'd17, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 32'd0, 1'b0);
    run_op("R9 slt equal", 5'd16, 32'd7, 32'd7, 16'h0, 5'd0, 32'd0, 1'b0);
    run_op("R9 slti", 5'd18, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 5'd0, 32'd1, 1'b0);
    run_op("R9 sltiu small", 5'd19, 32'd5, 32'd0, 16'hFFFF, 5'd0, 32'd1, 1'b0);
    run_op("R9 sltiu max", 5'd19, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 5'd0, 32'd0, 1'b0);
    run_op("R9 slt extremes", 5'd16, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, 32'd1, 1'b0);
  endtask

  task automatic t_lui_unused;
    run_op("R10 lui", 5'd20, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 16'h1234, 5'd7, 32'h1234_0000, 1'b0);
    run_op("R11 unused 21", 5'd21, 32'h7FFF_FFFF, 32'd1, 16'hFFFF, 5'd3, 32'd0, 1'b0);
    run_op("R11 unused 31", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 32'd0, 1'b0);
  endtask

  task automatic t_hold;
    run_op("R2 setup", 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 32'h8000_0000, 1'b1);
    op_sel = 5'd7; opa = 32'h1111_1111; opb = 32'h2222_2222; imm = 16'h5555; shamt = 5'd9;
    repeat (3) @(negedge clk);
    chk("R2 hold result", result, 32'h8000_0000);
    chk("R2 hold trap", {31'b0, ovf_trap}, 32'd1);
    chk("R2 valid low", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add_sub();
    t_imm_arith();
    t_logic();
    t_shift();
    t_compare();
    t_lui_unused();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule